// File: doc/BRIEF.md
# Auto-Restart Fault Sequencer

This block supervises a primary-side switch controller. It decides, clock by clock, whether the power switch may run. Its inputs are comparator flags for the supply rail, the sampled output-sense voltage, the line-sense current, die temperature and current sense, together with a strobe that marks the end of each switching period. Every fault has its own qualification filter. Some filters count clocks, as a stand-in for a time window. Others count consecutive switching periods.

Once a fault qualifies, switching stops and stays stopped. The only way out is for the supply to fall through its turn-off level and then climb back to its turn-on level. This is the auto-restart loop. A cause register records every fault that qualified in the tripping clock. It stays readable through the shutdown and clears when the next start begins. Undervoltage on the output is muted for a blanking window after each start. Brown-out supervision is armed only after the line has proved healthy for a run of switching periods.

Top module: `restart_guard`

## Requirements
- R1: While reset is high, and on the first clock after it, `sw_en` is 0 and `fault_cause` is 0.
- R2: Switching starts at the clock edge after `vdd_on_cmp` is seen high in the stopped state, with no over-temperature flag held. If `vdd_off_cmp` is seen while running with no fault, switching stops at the next edge and `fault_cause` stays 0.
- R3: Supply overvoltage trips after `vdd_ovp_cmp` is high for OVP_TICKS consecutive clocks. `sw_en` falls one edge later. A window broken by a single low clock does not trip.
- R4: Output overvoltage trips after CYC_N consecutive strobes, each with `out_ovp_cmp` high. A strobe with the flag low resets the count.
- R5: Output undervoltage trips after CYC_N consecutive strobes, each with `out_uvp_cmp` high. The count is held at zero for UVP_BLANK_TICKS clocks after each start.
- R6: Brown-out is armed only after CYC_N consecutive strobes with `line_bi_cmp` high. Once armed, `line_bo_cmp` high for BO_TICKS clocks trips.
- R7: Over-temperature has hysteresis. `temp_hot_cmp` sets a flag and `temp_cool_cmp` clears it. The flag trips a running block and blocks a new start until it is cleared.
- R8: `cs_short_cmp` seen at any time within a switching period, including the strobe clock itself, trips on that period's strobe. `sw_en` falls one edge after the strobe.
- R9: After a trip, `sw_en` stays 0 even with `vdd_on_cmp` high, until `vdd_off_cmp` has been seen and a new start follows.
- R10: Bit encoding of `fault_cause` is: bit0 supply overvoltage, bit1 output overvoltage, bit2 output undervoltage, bit3 brown-out, bit4 over-temperature, bit5 current-sense short. All faults qualifying in the tripping clock are recorded. The value is held until the start edge, where it clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_on_cmp | input | 1 | Supply above turn-on level |
| vdd_off_cmp | input | 1 | Supply below turn-off level |
| vdd_ovp_cmp | input | 1 | Supply above overvoltage level |
| cyc_strobe | input | 1 | One-clock pulse at the end of each switching period |
| out_ovp_cmp | input | 1 | Sampled output sense above overvoltage level |
| out_uvp_cmp | input | 1 | Sampled output sense below undervoltage level |
| line_bi_cmp | input | 1 | Line-sense current above brown-in level |
| line_bo_cmp | input | 1 | Line-sense current below brown-out level |
| temp_hot_cmp | input | 1 | Die temperature above trip point |
| temp_cool_cmp | input | 1 | Die temperature below release point |
| cs_short_cmp | input | 1 | Current sense above the short-circuit level |
| sw_en | output | 1 | Switching enable (registered) |
| fault_cause | output | 6 | Faults recorded at the last trip |

## Verification
A period-counted fault and the current-sense short can qualify on the same strobe. The output-overvoltage count reaches its limit on that strobe, and the short is registered on that same edge. To provoke this, the bench holds `out_ovp_cmp` high across the strobes and raises `cs_short_cmp` together with the final strobe. It then expects `sw_en` to fall one edge later with both bit1 and bit5 of `fault_cause` set. A trip that coincides with the supply's turn-off flag also falls in one cycle. There the design must still record the fault, because the fault takes priority over the plain stop.

// File: rtl/restart_pkg.sv
`timescale 1ns/1ps
package restart_pkg;
  localparam int NFAULT      = 6;
  localparam int F_VDD_OVP   = 0;
  localparam int F_OUT_OVP   = 1;
  localparam int F_OUT_UVP   = 2;
  localparam int F_BROWNOUT  = 3;
  localparam int F_OVERTEMP  = 4;
  localparam int F_CS_SHORT  = 5;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RUN   = 2'd1,
    ST_LATCH = 2'd2
  } run_state_e;
endpackage

// File: rtl/rg_time_filter.sv
`timescale 1ns/1ps
// Clock-counted qualification: hit once cond has held LIMIT consecutive clocks.
module rg_time_filter #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cond,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en || !cond) cnt_q <= '0;
    else if (cnt_q != LIM)   cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q == LIM);

  // R3 / R6: a qualified window implies the condition was present the clock before
  p_hit_after_cond_r3: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(cond && en));
endmodule

// File: rtl/rg_cycle_filter.sv
`timescale 1ns/1ps
// Period-counted qualification: hit after COUNT consecutive strobes with cond high.
module rg_cycle_filter #(
  parameter int unsigned COUNT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic strobe,
  input  logic cond,
  output logic hit
);
  localparam int W = $clog2(COUNT + 1);
  localparam logic [W-1:0] LIM = W'(COUNT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en)   cnt_q <= '0;
    else if (strobe) begin
      if (!cond)             cnt_q <= '0;
      else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit = (cnt_q == LIM);

  // R4: the count only moves on a strobe
  p_count_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !strobe) |=> $stable(cnt_q));
  // R4: a strobe with the condition absent restarts the count
  p_false_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (en && strobe && !cond) |=> (cnt_q == '0));
endmodule

// File: rtl/restart_guard.sv
`timescale 1ns/1ps
module restart_guard
  import restart_pkg::*;
#(
  parameter int unsigned OVP_TICKS       = 24000,
  parameter int unsigned BO_TICKS        = 3400000,
  parameter int unsigned UVP_BLANK_TICKS = 8000000,
  parameter int unsigned CYC_N           = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vdd_on_cmp,
  input  logic              vdd_off_cmp,
  input  logic              vdd_ovp_cmp,
  input  logic              cyc_strobe,
  input  logic              out_ovp_cmp,
  input  logic              out_uvp_cmp,
  input  logic              line_bi_cmp,
  input  logic              line_bo_cmp,
  input  logic              temp_hot_cmp,
  input  logic              temp_cool_cmp,
  input  logic              cs_short_cmp,
  output logic              sw_en,
  output logic [NFAULT-1:0] fault_cause
);
  localparam int BW = $clog2(UVP_BLANK_TICKS + 1);
  localparam logic [BW-1:0] BLANK_LIM = BW'(UVP_BLANK_TICKS);
  localparam int NCYC = 3;  // output OVP, output UVP, brown-in

  run_state_e st_q, st_d;
  logic run;
  assign run = (st_q == ST_RUN);

  // startup blanking for output undervoltage
  logic [BW-1:0] blank_q;
  logic          blank_done;
  always_ff @(posedge clk) begin
    if (rst || !run)  blank_q <= '0;
    else if (!blank_done) blank_q <= blank_q + 1'b1;
  end
  assign blank_done = (blank_q == BLANK_LIM);

  // period-counted filters
  logic [NCYC-1:0] cyc_en, cyc_cond, cyc_hit;
  assign cyc_en   = {run, run && blank_done, run};
  assign cyc_cond = {line_bi_cmp, out_uvp_cmp, out_ovp_cmp};

  for (genvar g = 0; g < NCYC; g++) begin : g_cyc
    rg_cycle_filter #(.COUNT(CYC_N)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .en     (cyc_en[g]),
      .strobe (cyc_strobe),
      .cond   (cyc_cond[g]),
      .hit    (cyc_hit[g])
    );
  end

  // line qualification arms the brown-out timer
  logic line_ok_q;
  always_ff @(posedge clk) begin
    if (rst || !run)  line_ok_q <= 1'b0;
    else if (cyc_hit[2]) line_ok_q <= 1'b1;
  end

  // clock-counted filters
  logic vovp_hit, bo_hit;
  rg_time_filter #(.LIMIT(OVP_TICKS)) u_vovp (
    .clk(clk), .rst(rst), .en(run), .cond(vdd_ovp_cmp), .hit(vovp_hit)
  );
  rg_time_filter #(.LIMIT(BO_TICKS)) u_bo (
    .clk(clk), .rst(rst), .en(run && line_ok_q), .cond(line_bo_cmp), .hit(bo_hit)
  );

  // over-temperature hysteresis flag
  logic otp_q;
  always_ff @(posedge clk) begin
    if (rst)                otp_q <= 1'b0;
    else if (temp_hot_cmp)  otp_q <= 1'b1;
    else if (temp_cool_cmp) otp_q <= 1'b0;
  end

  // current-sense short: remembered within the period, acted on at its strobe
  logic cs_seen_q, short_q;
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cs_seen_q <= 1'b0;
      short_q   <= 1'b0;
    end else begin
      short_q <= cyc_strobe && (cs_seen_q || cs_short_cmp);
      if (cyc_strobe)        cs_seen_q <= 1'b0;
      else if (cs_short_cmp) cs_seen_q <= 1'b1;
    end
  end

  logic [NFAULT-1:0] trip;
  always_comb begin
    trip             = '0;
    trip[F_VDD_OVP]  = vovp_hit;
    trip[F_OUT_OVP]  = cyc_hit[0];
    trip[F_OUT_UVP]  = cyc_hit[1];
    trip[F_BROWNOUT] = bo_hit;
    trip[F_OVERTEMP] = otp_q;
    trip[F_CS_SHORT] = short_q;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:   if (vdd_on_cmp && !otp_q) st_d = ST_RUN;
      ST_RUN:   if (|trip)                st_d = ST_LATCH;
                else if (vdd_off_cmp)     st_d = ST_OFF;
      ST_LATCH: if (vdd_off_cmp)          st_d = ST_OFF;
      default:                            st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_OFF;
      sw_en       <= 1'b0;
      fault_cause <= '0;
    end else begin
      st_q  <= st_d;
      sw_en <= (st_d == ST_RUN);
      if (run && (|trip))                         fault_cause <= trip;
      else if (st_q == ST_OFF && st_d == ST_RUN)  fault_cause <= '0;
    end
  end

  // R2: a start is always preceded by the turn-on flag
  p_start_needs_on_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en) |-> $past(vdd_on_cmp));
  // R5: undervoltage qualification is silent during blanking
  p_blank_mutes_uvp_r5: assert property (@(posedge clk) disable iff (rst)
    (run && !blank_done) |-> !cyc_hit[1]);
  // R9: a latched fault never re-enables switching directly
  p_latch_stays_off_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LATCH) |=> !sw_en);
  // R10: a stop not caused by turn-off carries a recorded cause
  p_trip_records_r10: assert property (@(posedge clk) disable iff (rst)
    ($fell(sw_en) && !$past(vdd_off_cmp)) |-> (fault_cause != '0));
  // R10: every start begins with an empty cause record
  p_start_clears_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en) |-> (fault_cause == '0));
endmodule

// File: tb/sim_restart_guard.sv
`timescale 1ns/1ps
module sim_restart_guard;
  localparam int OVP_T = 6;
  localparam int BO_T  = 10;
  localparam int BLANK = 40;
  localparam int NCY   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic on_c = 0, off_c = 0, vovp = 0, strb = 0, oovp = 0, ouvp = 0;
  logic bi = 0, bo = 0, hot = 0, cool = 0, cs = 0;
  logic       sw_en;
  logic [5:0] cause;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  restart_guard #(
    .OVP_TICKS(OVP_T), .BO_TICKS(BO_T), .UVP_BLANK_TICKS(BLANK), .CYC_N(NCY)
  ) u0 (
    .clk(clk), .rst(rst), .vdd_on_cmp(on_c), .vdd_off_cmp(off_c),
    .vdd_ovp_cmp(vovp), .cyc_strobe(strb), .out_ovp_cmp(oovp),
    .out_uvp_cmp(ouvp), .line_bi_cmp(bi), .line_bo_cmp(bo),
    .temp_hot_cmp(hot), .temp_cool_cmp(cool), .cs_short_cmp(cs),
    .sw_en(sw_en), .fault_cause(cause)
  );

  // kind[8:6], expected cause[5:0]
  localparam logic [8:0] VEC [6] = '{
    {3'd0, 6'b000001}, {3'd1, 6'b000010}, {3'd2, 6'b000100},
    {3'd3, 6'b001000}, {3'd4, 6'b010000}, {3'd5, 6'b100000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe_pulse();
    strb = 1; tick(1); strb = 0;
  endtask

  task automatic strobes(input int n);
    for (int k = 0; k < n; k++) begin strobe_pulse(); tick(1); end
  endtask

  task automatic power_cycle();
    off_c = 1; tick(2); off_c = 0;
    on_c = 1; cool = 1; tick(2); on_c = 0; cool = 0;
  endtask

  task automatic provoke(input logic [2:0] kind);
    case (kind)
      3'd0: begin  // R3
        vovp = 1; tick(OVP_T); chk("R3 still on at window end", sw_en, 1);
        tick(1); vovp = 0;
      end
      3'd1: begin  // R4
        oovp = 1; strobes(NCY-1); chk("R4 on before last strobe", sw_en, 1);
        strobe_pulse(); chk("R4 on at last strobe", sw_en, 1); tick(1); oovp = 0;
      end
      3'd2: begin  // R5
        tick(BLANK + 2);
        ouvp = 1; strobes(NCY-1); chk("R5 on before last strobe", sw_en, 1);
        strobe_pulse(); tick(1); ouvp = 0;
      end
      3'd3: begin  // R6
        bi = 1; strobes(NCY-1); strobe_pulse(); bi = 0; tick(1);
        bo = 1; tick(BO_T); chk("R6 on at window end", sw_en, 1);
        tick(1); bo = 0;
      end
      3'd4: begin  // R7
        hot = 1; tick(1); hot = 0; chk("R7 on one clock after hot", sw_en, 1);
        tick(1);
      end
      default: begin  // R8
        cs = 1; tick(1); cs = 0; tick(2); chk("R8 no trip before strobe", sw_en, 1);
        strobe_pulse(); chk("R8 on at strobe", sw_en, 1); tick(1);
      end
    endcase
  endtask

  initial begin
    tick(3);
    chk("R1 sw_en in reset", sw_en, 0);
    chk("R1 cause in reset", cause, 0);
    rst = 0; tick(1);
    chk("R1 sw_en after reset", sw_en, 0);
    tick(2);
    chk("R2 no start without turn-on", sw_en, 0);

    // table walk: each fault alone
    for (int i = 0; i < 6; i++) begin
      power_cycle();
      chk("R2 started", sw_en, 1);
      chk("R10 cleared at start", cause, 0);
      provoke(VEC[i][8:6]);
      chk("R3-R8 tripped (see kind)", sw_en, 0);
      chk("R10 cause bit", cause, {26'd0, VEC[i][5:0]});
    end

    // R2: plain stop on turn-off
    power_cycle();
    off_c = 1; tick(1); off_c = 0;
    chk("R2 stop on turn-off", sw_en, 0);
    chk("R2 no cause on plain stop", cause, 0);

    // R3: broken window
    power_cycle();
    vovp = 1; tick(OVP_T-1); vovp = 0; tick(1); vovp = 1; tick(OVP_T-1); vovp = 0; tick(2);
    chk("R3 broken window no trip", sw_en, 1);

    // R4: false strobe resets count
    oovp = 1; strobes(NCY-1); oovp = 0; strobes(1); oovp = 1; strobes(NCY-1);
    chk("R4 reset by false strobe", sw_en, 1);
    strobe_pulse(); tick(1); oovp = 0;
    chk("R4 trip after fresh run", sw_en, 0);
    chk("R10 cause output ovp", cause, 6'b000010);

    // R9: latch survives turn-on, released by turn-off then turn-on
    on_c = 1; tick(5);
    chk("R9 latched despite turn-on", sw_en, 0);
    on_c = 0; off_c = 1; tick(2); off_c = 0;
    chk("R10 cause held through turn-off", cause, 6'b000010);
    chk("R9 still off after turn-off", sw_en, 0);
    on_c = 1; tick(1); on_c = 0;
    chk("R9 restart after cycling", sw_en, 1);
    chk("R10 cleared on restart", cause, 0);

    // R5: undervoltage muted during blanking
    power_cycle();
    ouvp = 1; strobes(6);
    chk("R5 blanked", sw_en, 1);
    tick(BLANK); strobes(NCY-1);
    chk("R5 count from blank end", sw_en, 1);
    strobe_pulse(); tick(1); ouvp = 0;
    chk("R5 trip after blank", sw_en, 0);

    // R6: brown-out unarmed without brown-in
    power_cycle();
    bo = 1; tick(3*BO_T); bo = 0;
    chk("R6 brown-out unarmed", sw_en, 1);

    // R7: start blocked while hot flag held
    hot = 1; tick(1); hot = 0; tick(1);
    chk("R7 trip", sw_en, 0);
    off_c = 1; tick(2); off_c = 0; on_c = 1; tick(3);
    chk("R7 start blocked while hot", sw_en, 0);
    cool = 1; tick(2); cool = 0; on_c = 0;
    chk("R7 start after cool", sw_en, 1);

    // R8: short seen in the strobe clock itself
    cs = 1; strb = 1; tick(1); cs = 0; strb = 0;
    chk("R8 on at strobe edge", sw_en, 1);
    tick(1);
    chk("R8 short trip same-clock", sw_en, 0);
    chk("R10 cause short", cause, 6'b100000);

    // R10: two faults in one clock
    power_cycle();
    oovp = 1; strobes(NCY-1); cs = 1; strobe_pulse(); cs = 0; oovp = 0;
    chk("R10 on at joint strobe", sw_en, 1);
    tick(1);
    chk("R10 joint trip", sw_en, 0);
    chk("R10 both causes", cause, 6'b100010);

    // R10: fault and turn-off in the same clock
    power_cycle();
    vovp = 1; tick(OVP_T); off_c = 1; tick(1); off_c = 0; vovp = 0;
    chk("R10 fault wins over turn-off", cause, 6'b000001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog R1-level run: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule